// File: doc/BRIEF.md
# Predicated Two-Beat Vector Integer Unit

This block runs arithmetic and compare instructions on vectors of four 32-bit signed integer elements. Each instruction takes a second operand from one of two places. It is either a second vector, with element i paired with element i, or a single scalar that is paired with every element. The arithmetic operations are wrapping add, wrapping subtract, low-half multiply and signed saturating add. The three compares (equal, not-equal, signed less-than) produce one bit per element. Those bits go into a 4-bit mask register inside the block, not into a vector result.

An arithmetic instruction can be predicated by that mask. The block always computes all four result elements. It then reports which of them the destination should take through a per-element write enable, so a destination element whose enable is low keeps its old value. The execution datapath is only two elements wide. Each instruction is therefore processed in two beats: elements 0 and 1 on the cycle the instruction is accepted, and elements 2 and 3 on the next cycle. The input handshake stalls for that second beat.

Top module: `simd_vec_unit`

## Requirements
- R1: Opcode 0 adds, opcode 1 subtracts (A minus B) and opcode 2 multiplies, element by element. Each result is the low 32 bits of the exact result, so overflow wraps.
- R2: When `inScalarForm` is 1, `inScalar` is the second operand for every element, for both arithmetic and compare opcodes. `inSrcB` is then ignored. Element i occupies bits [32*i+31:32*i] of every vector port.
- R3: Opcode 3 is a signed saturating add. It gives 0x7FFFFFFF on positive overflow, 0x80000000 on negative overflow and the plain sum otherwise.
- R4: Opcodes 4 (equal), 5 (not equal) and 6 (signed less-than, A < B) set mask bit i to the compare result of element i. When such an instruction completes, `outMaskWe` is 1, `outElemWe` is 0000, and the new mask is on `outMask`.
- R5: An arithmetic instruction with `inPred`=1 completes with `outElemWe` equal to the mask register. With `inPred`=0 it completes with `outElemWe`=1111.
- R6: `inReady` is 1 when idle. An instruction is accepted at a rising edge where `inValid` and `inReady` are both 1. `inReady` is then 0 for the following cycle. `outValid` is 1 for exactly one cycle, starting at the second rising edge after acceptance, and `outResult` and the write enables are valid in that cycle.
- R7: `outElemWe` is 0000 and `outMaskWe` is 0 in every cycle where `outValid` is 0.
- R8: Opcode 7 is a no-op. It completes with `outValid` but with no element write enable, no mask write, and no change to the mask.
- R9: During and after reset, `inReady`=1, `outValid`=0 and the mask register is 1111.
- R10: `inValid` and operand changes during the second beat are ignored. They produce no extra completion, and they do not alter the in-flight result.
- R11: Only a compare changes the mask register. `outMask` shows the new value from the cycle in which that compare's `outValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present |
| inReady | output | 1 | Instruction can be accepted |
| inOp | input | 3 | Opcode (0 add, 1 sub, 2 mul, 3 sat add, 4 eq, 5 ne, 6 lt, 7 no-op) |
| inScalarForm | input | 1 | Use the scalar as the second operand |
| inPred | input | 1 | Predicate arithmetic by the mask register |
| inSrcA | input | 128 | First source vector |
| inSrcB | input | 128 | Second source vector |
| inScalar | input | 32 | Scalar operand |
| outValid | output | 1 | One-cycle completion strobe |
| outResult | output | 128 | Result vector |
| outElemWe | output | 4 | Per-element write enable |
| outMaskWe | output | 1 | Mask register was written by a compare |
| outMask | output | 4 | Current mask register |

## Verification
Every result is due in a single cycle: the second rising edge after the one that accepted the instruction. The driver records the cycle counter at the falling edge where it presents an instruction and stamps the expected item with that count plus two. The monitor samples only at falling edges and checks that each completion arrives exactly in its stamped cycle. The new mask from a compare is expected in that same completion cycle, and a predicated instruction issued right behind it must already see that mask. Because of this timing, back-to-back issue and junk driven during the stalled beat both expose any slip by one cycle.

// File: rtl/simd_vec_pkg.sv
package simd_vec_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_SADD = 3'd3,
    OP_CEQ  = 3'd4,
    OP_CNE  = 3'd5,
    OP_CLT  = 3'd6,
    OP_NOP  = 3'd7
  } vecOp_e;

  // Strobes from the sequencer to the datapath, one set per cycle.
  typedef struct packed {
    logic       load;        // instruction accepted this cycle, operands live
    logic       capture;     // a beat is executing this cycle
    logic [3:0] beatIdx;     // which element slice the beat covers
    vecOp_e     op;
    logic       scalarForm;
  } beatStrobe_t;

  function automatic logic isCompare(input vecOp_e op);
    return (op == OP_CEQ) || (op == OP_CNE) || (op == OP_CLT);
  endfunction

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_vec_pkg::*;
#(
  parameter int ELEM_W = 32
) (
  input  vecOp_e            op,
  input  logic [ELEM_W-1:0] a,
  input  logic [ELEM_W-1:0] b,
  output logic [ELEM_W-1:0] res,
  output logic              cmp
);

  localparam logic [ELEM_W-1:0] MAX_POS = {1'b0, {(ELEM_W-1){1'b1}}};
  localparam logic [ELEM_W-1:0] MAX_NEG = {1'b1, {(ELEM_W-1){1'b0}}};

  logic [ELEM_W:0]   wideSum;
  logic              sumOverflow;
  logic [ELEM_W-1:0] satSum;

  always_comb begin
    wideSum     = {a[ELEM_W-1], a} + {b[ELEM_W-1], b};
    sumOverflow = wideSum[ELEM_W] != wideSum[ELEM_W-1];
    satSum      = sumOverflow ? (wideSum[ELEM_W] ? MAX_NEG : MAX_POS)
                              : wideSum[ELEM_W-1:0];
  end

  always_comb begin
    res = '0;
    cmp = 1'b0;
    unique case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_SADD: res = satSum;
      OP_CEQ:  cmp = (a == b);
      OP_CNE:  cmp = (a != b);
      OP_CLT:  cmp = ($signed(a) < $signed(b));
      OP_NOP:  res = '0;
    endcase
  end

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_vec_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int ELEMS  = 4,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  beatStrobe_t             strobe,
  input  logic [ELEMS*ELEM_W-1:0] srcA,
  input  logic [ELEMS*ELEM_W-1:0] srcB,
  input  logic [ELEM_W-1:0]       srcScalar,
  output logic [ELEMS*ELEM_W-1:0] result,
  output logic [ELEMS-1:0]        cmpNext
);

  localparam int VEC_W   = ELEMS * ELEM_W;
  localparam int SLICE_W = LANES * ELEM_W;

  logic [VEC_W-1:0]   heldA, heldB, opA, opB, resultReg;
  logic [ELEM_W-1:0]  heldS, opS;
  logic [SLICE_W-1:0] sliceA, sliceB, sliceRes;
  logic [LANES-1:0]   sliceCmp;
  logic [ELEMS-1:0]   cmpReg;
  int                 sliceBase;
  int                 cmpBase;

  // Beat 0 reads the operands straight from the ports; later beats use the held copy.
  always_comb begin
    opA       = strobe.load ? srcA : heldA;
    opB       = strobe.load ? srcB : heldB;
    opS       = strobe.load ? srcScalar : heldS;
    sliceBase = int'(strobe.beatIdx) * SLICE_W;
    cmpBase   = int'(strobe.beatIdx) * LANES;
    sliceA    = opA[sliceBase +: SLICE_W];
    sliceB    = opB[sliceBase +: SLICE_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [ELEM_W-1:0] laneB;
    assign laneB = strobe.scalarForm ? opS : sliceB[g*ELEM_W +: ELEM_W];

    simd_lane_alu #(.ELEM_W(ELEM_W)) u_alu (
      .op  (strobe.op),
      .a   (sliceA[g*ELEM_W +: ELEM_W]),
      .b   (laneB),
      .res (sliceRes[g*ELEM_W +: ELEM_W]),
      .cmp (sliceCmp[g])
    );
  end

  always_comb begin
    cmpNext = cmpReg;
    if (strobe.capture) cmpNext[cmpBase +: LANES] = sliceCmp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldA     <= '0;
      heldB     <= '0;
      heldS     <= '0;
      resultReg <= '0;
      cmpReg    <= '0;
    end else begin
      if (strobe.load) begin
        heldA <= srcA;
        heldB <= srcB;
        heldS <= srcScalar;
      end
      if (strobe.capture) resultReg[sliceBase +: SLICE_W] <= sliceRes;
      cmpReg <= cmpNext;
    end
  end

  assign result = resultReg;

endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_vec_pkg::*;
#(
  parameter int ELEMS = 4,
  parameter int BEATS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  vecOp_e           inOp,
  input  logic             inScalarForm,
  input  logic             inPred,
  input  logic [ELEMS-1:0] cmpNext,
  output logic             inReady,
  output beatStrobe_t      strobe,
  output logic             outValid,
  output logic [ELEMS-1:0] outElemWe,
  output logic             outMaskWe,
  output logic [ELEMS-1:0] outMask
);

  localparam logic [3:0] LAST_BEAT = 4'(BEATS - 1);

  logic             busy;
  logic [3:0]       beatCnt;
  vecOp_e           opReg;
  logic             sfReg, predReg;
  logic             fire, lastBeat, curPred, curArith, curCmp;
  logic             validReg, maskWeReg;
  logic [ELEMS-1:0] weReg, maskReg;

  always_comb begin
    fire              = inValid && !busy;
    strobe.load       = fire;
    strobe.capture    = fire || busy;
    strobe.beatIdx    = busy ? beatCnt : 4'd0;
    strobe.op         = busy ? opReg : inOp;
    strobe.scalarForm = busy ? sfReg : inScalarForm;
    curPred           = busy ? predReg : inPred;
    curCmp            = isCompare(strobe.op);
    curArith          = !curCmp && (strobe.op != OP_NOP);
    lastBeat          = strobe.capture && (strobe.beatIdx == LAST_BEAT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      beatCnt   <= '0;
      opReg     <= OP_NOP;
      sfReg     <= 1'b0;
      predReg   <= 1'b0;
      validReg  <= 1'b0;
      weReg     <= '0;
      maskWeReg <= 1'b0;
      maskReg   <= '1;
    end else begin
      if (fire) begin
        opReg   <= inOp;
        sfReg   <= inScalarForm;
        predReg <= inPred;
      end
      if (strobe.capture) begin
        busy    <= !lastBeat;
        beatCnt <= lastBeat ? 4'd0 : strobe.beatIdx + 4'd1;
      end
      validReg  <= lastBeat;
      weReg     <= (lastBeat && curArith) ? (curPred ? maskReg : '1) : '0;
      maskWeReg <= lastBeat && curCmp;
      if (lastBeat && curCmp) maskReg <= cmpNext;
    end
  end

  assign inReady   = !busy;
  assign outValid  = validReg;
  assign outElemWe = weReg;
  assign outMaskWe = maskWeReg;
  assign outMask   = maskReg;

endmodule

// File: rtl/simd_vec_unit.sv
module simd_vec_unit
  import simd_vec_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int ELEMS  = 4,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [2:0]              inOp,
  input  logic                    inScalarForm,
  input  logic                    inPred,
  input  logic [ELEMS*ELEM_W-1:0] inSrcA,
  input  logic [ELEMS*ELEM_W-1:0] inSrcB,
  input  logic [ELEM_W-1:0]       inScalar,
  output logic                    outValid,
  output logic [ELEMS*ELEM_W-1:0] outResult,
  output logic [ELEMS-1:0]        outElemWe,
  output logic                    outMaskWe,
  output logic [ELEMS-1:0]        outMask
);

  localparam int BEATS = ELEMS / LANES;

  beatStrobe_t      strobe;
  logic [ELEMS-1:0] cmpNext;

  simd_ctrl #(.ELEMS(ELEMS), .BEATS(BEATS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inOp         (vecOp_e'(inOp)),
    .inScalarForm (inScalarForm),
    .inPred       (inPred),
    .cmpNext      (cmpNext),
    .inReady      (inReady),
    .strobe       (strobe),
    .outValid     (outValid),
    .outElemWe    (outElemWe),
    .outMaskWe    (outMaskWe),
    .outMask      (outMask)
  );

  simd_datapath #(.ELEM_W(ELEM_W), .ELEMS(ELEMS), .LANES(LANES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcA      (inSrcA),
    .srcB      (inSrcB),
    .srcScalar (inScalar),
    .result    (outResult),
    .cmpNext   (cmpNext)
  );

endmodule

// File: rtl/simd_vec_unit_chk.sv
module simd_vec_unit_chk #(
  parameter int ELEMS = 4,
  parameter int BEATS = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic [ELEMS-1:0] outElemWe,
  input logic             outMaskWe,
  input logic [ELEMS-1:0] outMask
);

  if (BEATS > 1) begin : gMultiBeat
    // R6: after acceptance the input stalls for the next beat
    assert_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inReady) |=> !inReady);
    // R6: completion strobe lasts one cycle
    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
      outValid |=> !outValid);
  end

  if (BEATS == 2) begin : gTwoBeat
    // R6: completion two edges after acceptance
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inReady) |-> ##2 outValid);
  end

  // R7: no write enables outside completion
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outElemWe == '0 && !outMaskWe));

  // R4: a mask write never comes with element writes
  assert_cmp_novec_R4: assert property (@(posedge clk) disable iff (!rstN)
    outMaskWe |-> (outElemWe == '0));

  // R11: mask only moves together with a mask write
  assert_mask_src_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outMask != $past(outMask)) |-> outMaskWe);

endmodule

bind simd_vec_unit simd_vec_unit_chk #(.ELEMS(ELEMS), .BEATS(BEATS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .outValid  (outValid),
  .outElemWe (outElemWe),
  .outMaskWe (outMaskWe),
  .outMask   (outMask)
);

// File: tb/simd_vec_unit_tb.sv
module simd_vec_unit_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [2:0]   inOp = 3'd0;
  logic         inScalarForm = 1'b0;
  logic         inPred = 1'b0;
  logic [127:0] inSrcA = '0;
  logic [127:0] inSrcB = '0;
  logic [31:0]  inScalar = '0;
  logic         outValid;
  logic [127:0] outResult;
  logic [3:0]   outElemWe;
  logic         outMaskWe;
  logic [3:0]   outMask;

  always #10 clk = ~clk;

  simd_vec_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOp(inOp), .inScalarForm(inScalarForm), .inPred(inPred),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inScalar(inScalar),
    .outValid(outValid), .outResult(outResult), .outElemWe(outElemWe),
    .outMaskWe(outMaskWe), .outMask(outMask)
  );

  typedef struct {
    logic [127:0] res;
    bit           chkRes;
    logic [3:0]   we;
    logic         maskWe;
    logic [3:0]   mask;
    int           due;
    string        tag;
  } exp_t;

  exp_t       sbQ[$];
  int         checks = 0;
  int         failures = 0;
  int         cyc = 0;
  int         sent = 0;
  int         seen = 0;
  logic [3:0] mdlMask = 4'b1111;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refElem(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
    logic signed [32:0] w;
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a * b;
      3'd3: begin
        w = $signed({a[31], a}) + $signed({b[31], b});
        if (w > 33'sh07FFFFFFF) return 32'h7FFFFFFF;
        else if (w < -33'sh080000000) return 32'h80000000;
        else return w[31:0];
      end
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic refCmp(input logic [2:0] op, input logic [31:0] a,
                                  input logic [31:0] b);
    case (op)
      3'd4: return a == b;
      3'd5: return a != b;
      3'd6: return $signed(a) < $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [127:0] v4(input logic [31:0] e0, e1, e2, e3);
    return {e3, e2, e1, e0};
  endfunction

  // Driver: issues one instruction and pushes its expected completion.
  task automatic send(input logic [2:0] op, input bit sf, input bit pred,
                      input logic [127:0] a, input logic [127:0] b,
                      input logic [31:0] s, input bit junk, input string tag);
    exp_t e;
    logic [3:0] bits;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inOp = op; inScalarForm = sf; inPred = pred;
    inSrcA = a; inSrcB = b; inScalar = s; inValid = 1'b1;
    bits = '0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] bi;
      bi = sf ? s : b[32*i +: 32];
      e.res[32*i +: 32] = refElem(op, a[32*i +: 32], bi);
      bits[i] = refCmp(op, a[32*i +: 32], bi);
    end
    if (op >= 3'd4 && op <= 3'd6) begin
      mdlMask = bits;
      e.chkRes = 1'b0; e.we = 4'b0000; e.maskWe = 1'b1;
    end else if (op == 3'd7) begin
      e.chkRes = 1'b0; e.we = 4'b0000; e.maskWe = 1'b0;
    end else begin
      e.chkRes = 1'b1; e.we = pred ? mdlMask : 4'b1111; e.maskWe = 1'b0;
    end
    e.mask = mdlMask;
    e.due  = cyc + 2;
    e.tag  = tag;
    sbQ.push_back(e);
    sent++;
    @(negedge clk);
    if (junk) begin
      // R10: garbage offered while the unit is in its second beat
      inSrcA = ~a; inSrcB = ~b; inScalar = ~s; inOp = 3'd2; inPred = ~pred;
      inValid = 1'b1;
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  // Monitor: pops and compares at each completion.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      seen++;
      if (sbQ.size() == 0) begin
        check(1'b0, "R10", "unexpected completion", 128'(outValid), 128'(0));
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        check(cyc == e.due, "R6", {e.tag, " completion cycle"}, 128'(cyc), 128'(e.due));
        check(outElemWe == e.we, e.tag, "element write enable", 128'(outElemWe), 128'(e.we));
        check(outMaskWe == e.maskWe, e.tag, "mask write", 128'(outMaskWe), 128'(e.maskWe));
        check(outMask == e.mask, "R11", {e.tag, " mask value"}, 128'(outMask), 128'(e.mask));
        if (e.chkRes)
          check(outResult == e.res, e.tag, "result", outResult, e.res);
      end
    end
    if (rstN && !outValid)
      check(outElemWe == 4'b0 && !outMaskWe, "R7", "enables while idle",
            128'({outElemWe, outMaskWe}), 128'(0));
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(inReady == 1'b1, "R9", "ready in reset", 128'(inReady), 128'(1));
    check(outValid == 1'b0, "R9", "valid in reset", 128'(outValid), 128'(0));
    check(outMask == 4'b1111, "R9", "mask in reset", 128'(outMask), 128'hF);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1 && outValid == 1'b0, "R9", "idle after reset",
          128'({inReady, outValid}), 128'b10);

    // R5: predicated with reset mask enables all four
    send(3'd0, 0, 1, v4(1, 2, 3, 4), v4(10, 20, 30, 40), 0, 0, "R5");
    // R1: wrapping arithmetic
    send(3'd0, 0, 0, v4(1, 32'hFFFFFFFF, 32'h7FFFFFFF, 10),
         v4(2, 1, 1, 32'hFFFFFFF6), 0, 0, "R1");
    send(3'd1, 0, 0, v4(5, 0, 32'h80000000, 100), v4(7, 1, 1, 100), 0, 0, "R1");
    send(3'd2, 0, 0, v4(3, 32'h10000, 32'hFFFFFFFE, 32'h12345),
         v4(5, 32'h10000, 7, 32'h1000), 0, 0, "R1");
    // R3: saturation in both directions and no saturation
    send(3'd3, 0, 0, v4(32'h7FFFFFF0, 32'h80000005, 32'h7FFFFFFF, 32'hFFFFFFFF),
         v4(32'h20, 32'hFFFFFFF0, 32'h80000000, 32'hFFFFFFFF), 0, 0, "R3");
    // R2: scalar form, inSrcB holds decoys
    send(3'd0, 1, 0, v4(1, 2, 3, 4), v4(32'hDEAD, 32'hBEEF, 9, 9), 100, 0, "R2");
    send(3'd3, 1, 0, v4(1, 32'hFFFFFFFF, 0, 32'h80000000), '1, 32'h7FFFFFFF, 0, "R2");
    // R4: compare equal, mask 0101
    send(3'd4, 0, 0, v4(1, 2, 3, 4), v4(1, 0, 3, 0), 0, 0, "R4");
    // R5: predicated right behind the compare
    send(3'd0, 0, 1, v4(5, 6, 7, 8), v4(1, 1, 1, 1), 0, 0, "R5");
    send(3'd1, 0, 0, v4(5, 6, 7, 8), v4(1, 1, 1, 1), 0, 0, "R5");
    // R8: no-op leaves mask and writes nothing
    send(3'd7, 0, 1, v4(1, 2, 3, 4), v4(1, 2, 3, 4), 0, 0, "R8");
    // R4: signed less-than against scalar zero, mask 1001
    send(3'd6, 1, 0, v4(32'hFFFFFFFB, 5, 0, 32'hFFFFFFFF), '0, 0, 0, "R4");
    // R10: junk during the second beat of a predicated multiply
    send(3'd2, 0, 1, v4(2, 3, 4, 5), v4(6, 7, 8, 9), 0, 1, "R10");
    // R4: not-equal vs scalar, mask 0100
    send(3'd5, 1, 0, v4(7, 7, 8, 7), '0, 7, 0, "R4");
    send(3'd3, 0, 1, v4(32'h7FFFFFFF, 1, 32'h7FFFFFFF, 1), v4(1, 1, 1, 1), 0, 0, "R5");
    // R4: all-false compare then predicated op writes nothing
    send(3'd6, 0, 0, v4(5, 5, 5, 5), v4(1, 2, 3, 4), 0, 0, "R4");
    send(3'd0, 0, 1, v4(1, 1, 1, 1), v4(1, 1, 1, 1), 0, 1, "R5");
    // mixed stream
    for (int k = 0; k < 40; k++) begin
      logic [2:0] rop;
      rop = 3'($urandom_range(0, 7));
      send(rop, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, $urandom,
           bit'($urandom_range(0, 1)), "R1");
    end

    repeat (6) @(negedge clk);
    check(sbQ.size() == 0, "R10", "pending completions", 128'(sbQ.size()), 128'(0));
    check(seen == sent, "R10", "completion count", 128'(seen), 128'(sent));
    check(outMask == mdlMask, "R11", "final mask", 128'(outMask), 128'(mdlMask));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule